// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps a free-running 32-bit count of seconds and compares it with a single programmable alarm value. A host reaches it over a narrow 8-bit register bus, one byte per access. The bus has an address, a write strobe, a read strobe and data lines. The count advances on a one-cycle tick input, which an external prescaler supplies once per second. The block does not generate the tick itself.

Software loads a new time through a four-byte staging window. Bytes 1 to 3 only update the staged copy. A write to byte 0 moves the whole staged value into the running counter in one cycle, so the upper bytes must be written first. Reads of the count come straight from the live counter with no snapshot. A carry that lands between two byte reads can therefore tear the value. Software detects this by reading byte 0 a second time and seeing that it has become smaller. The alarm raises a pending flag and a level interrupt when the counter steps onto the programmed value. Software acknowledges the alarm by writing the flag bit back as zero.

Top module: `sec_rtc`

## Requirements
- R1: After reset the counter, the alarm value, both control bits and the pending flag are zero, and `alarm_irq` is low.
- R2: Bit 7 of the control register at offset 0x00 is the run enable. While it is clear, ticks leave the counter unchanged.
- R3: The control register keeps only bit 7 (run) and bit 1 (alarm enable). Reading offset 0x00 returns 0 in every other bit, whatever value was written.
- R4: A write to offset 0x02 loads the counter with the written byte as bits 7:0 and the staged bytes as bits 31:8. The counter reads back little-endian at offsets 0x06 (bits 7:0) through 0x09 (bits 31:24).
- R5: Writes to offsets 0x03, 0x04 and 0x05 (staged bytes 1, 2, 3) leave the running counter unchanged.
- R6: A tick while running adds one to the 32-bit count, with the carry propagating across byte boundaries. Reads return the live value.
- R7: When a tick coincides with a write to offset 0x02, the written value wins and the tick is lost.
- R8: The alarm value is readable and writable byte by byte at offsets 0x0A (bits 7:0) through 0x0D (bits 31:24).
- R9: When a running tick makes the counter equal to the alarm value and control bit 1 is set, the pending flag sets and `alarm_irq` rises. With bit 1 clear, no alarm is raised.
- R10: The pending flag reads as bit 0 of offset 0x01. Writing 0x01 with bit 0 clear clears it. Writing with bit 0 set leaves it unchanged. `alarm_irq` follows the flag.
- R11: A read strobe updates `rd_data` on the next clock edge. Offsets 0x02–0x05 and every offset above 0x0D read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_addr | input | 8 | Register offset from the control register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, registered |
| alarm_irq | output | 1 | Alarm interrupt, high while the alarm is pending |

## Verification
The hardest case to reach is a byte-0 commit that arrives in the same clock cycle as a tick. A host cannot normally line these up, so the bench drives the write strobe and the tick on the same falling edge. It then checks that the committed byte shows up without the increment. The alarm gate is also awkward, because the count has to land on the alarm value exactly. The bench sets the alarm one step ahead of the count with the enable clear, confirms that no interrupt appears, and then re-arms the alarm one step further with the enable set.

// File: rtl/sec_rtc_pkg.sv
// Shared constants for the seconds RTC: register offsets and control bit positions.
// Assumes a byte-wide bus and a counter made of NB_BYTES bytes.
package sec_rtc_pkg;
    localparam int NB_BYTES    = 4;
    localparam int OFS_CTRL    = 8'h00;
    localparam int OFS_ACTL    = 8'h01;
    localparam int OFS_STAGE   = 8'h02;
    localparam int OFS_LIVE    = 8'h06;
    localparam int OFS_ALARM   = 8'h0A;
    localparam int BIT_RUN     = 7;
    localparam int BIT_AEN     = 1;
    localparam int BIT_PEND    = 0;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/sec_rtc_decode.sv
// Address decoder: turns a byte offset into hit lines for each register.
// Purely combinational; the caller gates the hits with its own strobes.
module sec_rtc_decode
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NB     = NB_BYTES
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ctrl,
    output logic              hit_actl,
    output logic [NB-1:0]     hit_stage,
    output logic [NB-1:0]     hit_live,
    output logic [NB-1:0]     hit_alarm
);
    // Single-register hits.
    always_comb begin
        hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
        hit_actl = (addr == ADDR_W'(OFS_ACTL));
    end

    // One hit per byte of each multi-byte window.
    for (genvar i = 0; i < NB; i++) begin : g_win
        assign hit_stage[i] = (addr == ADDR_W'(OFS_STAGE + i));
        assign hit_live[i]  = (addr == ADDR_W'(OFS_LIVE + i));
        assign hit_alarm[i] = (addr == ADDR_W'(OFS_ALARM + i));
    end
endmodule

// File: rtl/sec_rtc_count.sv
// Seconds counter with staged load. Bytes 1..NB-1 are held in a staging array;
// a byte-0 write commits them together with the written byte and beats a tick.
// Assumes at most one write strobe per cycle.
module sec_rtc_count
    import sec_rtc_pkg::*;
#(
    parameter int NB = NB_BYTES,
    localparam int W = 8 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic [NB-1:0] stage_we,
    input  byte_t         wdata,
    output logic [W-1:0]  cnt,
    output logic [W-1:0]  cnt_next,
    output logic          adv
);
    byte_t        stage_b [1:NB-1];
    logic [W-1:0] commit_val;
    logic         commit;

    assign commit   = stage_we[0];
    assign cnt_next = cnt + W'(1);
    assign adv      = tick && run && !commit;

    // Staged upper bytes, each loaded by its own window write.
    for (genvar i = 1; i < NB; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)           stage_b[i] <= '0;
            else if (stage_we[i]) stage_b[i] <= wdata;
        end
    end

    // Assemble the value a byte-0 write loads.
    always_comb begin
        commit_val[7:0] = wdata;
        for (int i = 1; i < NB; i++) commit_val[8*i +: 8] = stage_b[i];
    end

    // Running counter: commit wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (commit) cnt <= commit_val;
        else if (adv)    cnt <= cnt_next;
    end

    a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !commit) |=> $stable(cnt));
    a_r5_stage_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stage_we[NB-1:1]) && !tick) |=> $stable(cnt));
    a_r7_commit_byte0: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt[7:0] == $past(wdata)));
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !commit) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/sec_rtc_alarm.sv
// Alarm value register, match detection and the pending flag.
// A match counts only on a cycle where the counter advances onto the alarm value.
module sec_rtc_alarm
    import sec_rtc_pkg::*;
#(
    parameter int NB = NB_BYTES,
    localparam int W = 8 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] alarm_we,
    input  logic          actl_we,
    input  byte_t         wdata,
    input  logic          aen,
    input  logic          adv,
    input  logic [W-1:0]  cnt_next,
    output logic [W-1:0]  alarm_val,
    output logic          pending
);
    byte_t alm_b [NB];
    logic  fire;
    logic  ack;

    // Alarm bytes, written one at a time.
    for (genvar i = 0; i < NB; i++) begin : g_alm
        always_ff @(posedge clk) begin
            if (!rst_n)           alm_b[i] <= '0;
            else if (alarm_we[i]) alm_b[i] <= wdata;
        end
    end

    // Pack the bytes little-endian.
    always_comb begin
        for (int i = 0; i < NB; i++) alarm_val[8*i +: 8] = alm_b[i];
    end

    assign fire = adv && aen && (cnt_next == alarm_val);
    assign ack  = actl_we && !wdata[BIT_PEND];

    // Pending flag: a new match outranks a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (fire) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end

    a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(aen && adv));
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire) |=> !pending);
    a_r10_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && actl_we && wdata[BIT_PEND]) |=> pending);
endmodule

// File: rtl/sec_rtc.sv
// Top of the seconds RTC: control bits, bus strobes, registered read mux.
// Assumes the bus raises at most one of write or read strobe per cycle.
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NB     = NB_BYTES,
    localparam int W     = 8 * NB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              alarm_irq
);
    logic          hit_ctrl, hit_actl;
    logic [NB-1:0] hit_stage, hit_live, hit_alarm;
    logic          run, aen, pending, adv;
    logic [W-1:0]  cnt, cnt_next, alarm_val;
    byte_t         rd_mux;

    sec_rtc_decode #(.ADDR_W(ADDR_W), .NB(NB)) u_dec (
        .addr(bus_addr), .hit_ctrl(hit_ctrl), .hit_actl(hit_actl),
        .hit_stage(hit_stage), .hit_live(hit_live), .hit_alarm(hit_alarm)
    );

    sec_rtc_count #(.NB(NB)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .run(run),
        .stage_we(hit_stage & {NB{bus_wr}}), .wdata(wr_data),
        .cnt(cnt), .cnt_next(cnt_next), .adv(adv)
    );

    sec_rtc_alarm #(.NB(NB)) u_alm (
        .clk(clk), .rst_n(rst_n), .alarm_we(hit_alarm & {NB{bus_wr}}),
        .actl_we(hit_actl && bus_wr), .wdata(wr_data), .aen(aen),
        .adv(adv), .cnt_next(cnt_next), .alarm_val(alarm_val), .pending(pending)
    );

    // Control register: only run and alarm-enable are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            aen <= 1'b0;
        end else if (bus_wr && hit_ctrl) begin
            run <= wr_data[BIT_RUN];
            aen <= wr_data[BIT_AEN];
        end
    end

    // Select the byte for the current offset; unmapped offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[BIT_RUN] = run;
            rd_mux[BIT_AEN] = aen;
        end
        if (hit_actl) rd_mux[BIT_PEND] = pending;
        for (int i = 0; i < NB; i++) begin
            if (hit_live[i])  rd_mux = rd_mux | cnt[8*i +: 8];
            if (hit_alarm[i]) rd_mux = rd_mux | alarm_val[8*i +: 8];
        end
    end

    // Register the read byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (bus_rd) rd_data <= rd_mux;
    end

    assign alarm_irq = pending;

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr > ADDR_W'(OFS_ALARM + NB - 1))) |=> (rd_data == 8'h00));
    a_r3_ctrl_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_ctrl) |=> ((rd_data & 8'h7D) == 8'h00));
endmodule

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       sec_tick = 0;
    logic [7:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic       bus_rd = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       alarm_irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    sec_rtc uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .wr_data(wr_data),
        .rd_data(rd_data), .alarm_irq(alarm_irq)
    );

    // Monitor: a read strobe seen at an edge yields data by the next falling edge.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s: rd_data=%02h expected %02h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        bus_addr = a; wr_data = d; bus_wr = 1; sec_tick = tk;
        @(negedge clk);
        bus_wr = 0; sec_tick = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_tests++;
        if (alarm_irq !== e) begin
            n_fail++;
            $display("FAIL %s: alarm_irq=%0b expected %0b", t, alarm_irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk_irq(0, "R1 irq after reset");
        rd(8'h00, 8'h00, "R1 ctrl reset");
        for (int i = 0; i < 4; i++) rd(8'(8'h06 + i), 8'h00, "R1 count reset");
        rd(8'h0A, 8'h00, "R1 alarm reset");
        // R2: halted counter ignores ticks
        tick(); tick(); tick();
        rd(8'h06, 8'h00, "R2 halted count");
        // R3: only bits 7 and 1 are kept
        wr(8'h00, 8'hFF, 0);
        rd(8'h00, 8'h82, "R3 ctrl bits");
        wr(8'h00, 8'h80, 0);
        rd(8'h00, 8'h80, "R3 ctrl run only");
        // R4/R5: staged load
        wr(8'h02, 8'h00, 0);
        wr(8'h03, 8'h11, 0);
        wr(8'h04, 8'h22, 0);
        wr(8'h05, 8'h33, 0);
        rd(8'h07, 8'h00, "R5 byte1 unchanged");
        rd(8'h09, 8'h00, "R5 byte3 unchanged");
        wr(8'h02, 8'hFE, 0);
        rd(8'h06, 8'hFE, "R4 byte0");
        rd(8'h07, 8'h11, "R4 byte1");
        rd(8'h08, 8'h22, "R4 byte2");
        rd(8'h09, 8'h33, "R4 byte3");
        // R6: increment with carry, live read
        tick();
        rd(8'h06, 8'hFF, "R6 plus one");
        tick();
        rd(8'h06, 8'h00, "R6 carry byte0");
        rd(8'h07, 8'h12, "R6 carry byte1");
        // R7: commit beats same-cycle tick
        wr(8'h02, 8'h40, 1);
        rd(8'h06, 8'h40, "R7 commit wins");
        rd(8'h07, 8'h11, "R7 staged upper");
        // R8: alarm register
        wr(8'h0A, 8'h41, 0);
        wr(8'h0B, 8'h11, 0);
        wr(8'h0C, 8'h22, 0);
        wr(8'h0D, 8'h33, 0);
        rd(8'h0A, 8'h41, "R8 alarm byte0");
        rd(8'h0D, 8'h33, "R8 alarm byte3");
        // R9: match with enable clear raises nothing
        tick();
        chk_irq(0, "R9 gated by enable");
        rd(8'h01, 8'h00, "R9 no pending when disabled");
        wr(8'h0A, 8'h42, 0);
        wr(8'h00, 8'h82, 0);
        tick();
        chk_irq(1, "R9 alarm fires");
        rd(8'h01, 8'h01, "R10 pending bit");
        // R10: write of one keeps, zero clears
        wr(8'h01, 8'h01, 0);
        chk_irq(1, "R10 one keeps pending");
        wr(8'h01, 8'h00, 0);
        chk_irq(0, "R10 zero clears");
        rd(8'h01, 8'h00, "R10 pending cleared");
        // R11: unmapped and write window read zero
        rd(8'h03, 8'h00, "R11 stage window reads zero");
        rd(8'h0E, 8'h00, "R11 offset 0x0E");
        rd(8'hA7, 8'h00, "R11 high offset");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule